// File: doc/BRIEF.md
# Streaming 3x3 Sliding Window Buffer

The block takes a feature map delivered one pixel word per handshake in raster order, with each word carrying all channel bits of one position. For a downstream processing element it produces every 3x3 window of that map, stride one and no padding. Each window goes out as nine separate words on a valid/ready stream. The words come in row-major kernel order: top-left first, bottom-right last. Windows follow the same raster order as the input. They move along a row of positions, then drop down by one row.

Storage is three row slots, each as wide as the largest supported map. The slots are used circularly: a new input row replaces the oldest one. The block never holds a whole frame. The input stream is throttled whenever the next pixel would replace data that a window still has to read. Image width and height come from configuration inputs and must stay constant for the whole frame. When the last element of a frame has been consumed, the block returns to its start state and the next frame can begin at once.

Top module: `tri_row_window`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Element k (0..8) of the window whose bottom-right pixel is (r, c) carries the input pixel at row r-2+k/3, column c-2+k%3. Once a window has started, its elements are presented back to back with no gap in `out_valid`.
- R3: A WxH frame yields exactly (W-2)*(H-2) windows. Windows are ordered by bottom-right column within a row of positions, then by row.
- R4: `out_valid` for window (r, c) rises only once the pixel at linear position r*W+c has been accepted, and it is high from then on until that window's elements are consumed.
- R5: The next input pixel (i, j) with i >= 3 is accepted only when all windows whose bottom row is below i-1 have been consumed, together with windows (i-1, c) for every c <= j+2. Rows 0 to 2 are never held back.
- R6: `out_win_last` is 1 on element 8 of every window and 0 otherwise. `out_frame_last` is 1 only on element 8 of the last window of the frame.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_win_last` and `out_frame_last` do not change.
- R8: After the final pixel of a frame, `in_ready` stays 0 until the final window element is consumed. In the cycle after that, the block accepts row 0 of a new frame and presents nothing.
- R9: Any width from 3 to MAX_W and any height from 3 to MAX_H works, including the 3x3 case that has a single window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_width | input | CW | Feature-map width in pixels (3..MAX_W) |
| cfg_height | input | RW | Feature-map height in rows (3..MAX_H) |
| in_valid | input | 1 | Input pixel word offered |
| in_data | input | PIX_W | Input pixel word (all channel bits) |
| in_ready | output | 1 | Block can take the offered pixel |
| out_valid | output | 1 | Window element offered |
| out_data | output | PIX_W | Window element pixel word |
| out_win_last | output | 1 | Element is the ninth of its window |
| out_frame_last | output | 1 | Element closes the last window of the frame |
| out_ready | input | 1 | Consumer takes the offered element |

## Verification
The critical overlap is a pixel being written into a row slot in the same cycle that a window element is read from the store. This bites hardest when the write lands in the slot and column that the current window is about to leave. The bench provokes it by running both streams at full rate, and also with independent random stalls on each side, over several widths and heights. A behavioural model built on accepted-pixel and consumed-element counts predicts `in_ready` and `out_valid` each cycle, and predicts the exact pixel each element must carry. Any write that overtakes a pending read therefore shows up as a wrong word or as a ready that arrives too early.

// File: rtl/tw_pkg.sv
// Package tw_pkg: shared slot type and modulo-3 slot helpers for the
// three-row circular window store. Assumes slot codes 0..2 only.
package tw_pkg;

    typedef logic [1:0] slot_t;

    // Advance a slot index by one, wrapping 2 -> 0.
    function automatic slot_t slot_step(slot_t s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction

    // Add an offset of 0..2 to a slot index, modulo 3.
    function automatic slot_t slot_offset(slot_t s, logic [1:0] n);
        logic [2:0] t;
        t = {1'b0, s} + {1'b0, n};
        return (t >= 3'd3) ? slot_t'(t - 3'd3) : slot_t'(t);
    endfunction

endpackage

// File: rtl/row_store.sv
// Module row_store: three row slots of DEPTH pixel words each. One
// synchronous write port and one combinational read port.
// Assumes the caller never writes a location in the cycle it reads it.
module row_store #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             wr_en,
    input  tw_pkg::slot_t    wr_slot,
    input  logic [AW-1:0]    wr_col,
    input  logic [PIX_W-1:0] wr_data,
    input  tw_pkg::slot_t    rd_slot,
    input  logic [AW-1:0]    rd_col,
    output logic [PIX_W-1:0] rd_data
);
    logic [PIX_W-1:0] slot_q [3];

    for (genvar g = 0; g < 3; g++) begin : g_slot
        logic [PIX_W-1:0] mem [DEPTH];

        // Store an accepted pixel into this slot when it is the target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == tw_pkg::slot_t'(g)))
                mem[wr_col] <= wr_data;
        end

        assign slot_q[g] = mem[rd_col];
    end

    // Select the slot holding the requested window row.
    always_comb begin
        case (rd_slot)
            2'd0:    rd_data = slot_q[0];
            2'd1:    rd_data = slot_q[1];
            default: rd_data = slot_q[2];
        endcase
    end
endmodule

// File: rtl/pixel_loader.sv
// Module pixel_loader: tracks the raster position of the next input pixel
// and decides whether it may be accepted without clobbering a row that a
// pending window still needs. Assumes the reader never lags more than one
// row behind once row 3 has started.
module pixel_loader #(
    parameter int CW = 6,
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_width,
    input  logic [RW-1:0] cfg_height,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [RW-1:0] rd_row,
    input  logic [CW-1:0] rd_col,
    input  logic          frame_done,
    output logic [RW-1:0] wr_row,
    output logic [CW-1:0] wr_col,
    output tw_pkg::slot_t wr_slot,
    output logic          wr_en,
    output logic          frame_full
);
    import tw_pkg::*;

    logic [CW:0]   col_need;
    logic          lag_ok;
    logic [CW-1:0] last_col;
    logic [RW-1:0] last_row;

    assign last_col = cfg_width - CW'(1);
    assign last_row = cfg_height - RW'(1);

    // Overwriting column j of the oldest row is safe once the reader is past column j+2.
    always_comb begin
        col_need = {1'b0, wr_col} + (CW+1)'(3);
        lag_ok   = (rd_row == wr_row - RW'(1)) && ({1'b0, rd_col} >= col_need);
        in_ready = !frame_full &&
                   ((wr_row < RW'(3)) || (rd_row >= wr_row) || lag_ok);
    end

    assign wr_en = in_valid && in_ready;

    // Advance the write position and mark the frame complete on its last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_row     <= '0;
            wr_col     <= '0;
            wr_slot    <= 2'd0;
            frame_full <= 1'b0;
        end else if (frame_done) begin
            frame_full <= 1'b0;
        end else if (wr_en) begin
            if (wr_col == last_col) begin
                wr_col <= '0;
                if (wr_row == last_row) begin
                    wr_row     <= '0;
                    wr_slot    <= 2'd0;
                    frame_full <= 1'b1;
                end else begin
                    wr_row  <= wr_row + RW'(1);
                    wr_slot <= slot_step(wr_slot);
                end
            end else begin
                wr_col <= wr_col + CW'(1);
            end
        end
    end
endmodule

// File: rtl/window_walker.sv
// Module window_walker: steps through window positions and the nine
// kernel elements of each, in row-major kernel order, and addresses the
// row store. Assumes width and height are at least 3 and stay fixed
// during a frame.
module window_walker #(
    parameter int CW = 6,
    parameter int RW = 6,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_width,
    input  logic [RW-1:0] cfg_height,
    input  logic [RW-1:0] wr_row,
    input  logic [CW-1:0] wr_col,
    input  logic          frame_full,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          win_last,
    output logic          frame_last,
    output tw_pkg::slot_t sel_slot,
    output logic [AW-1:0] sel_col,
    output logic [RW-1:0] rd_row,
    output logic [CW-1:0] rd_col,
    output logic          frame_done
);
    import tw_pkg::*;

    logic [1:0]    kr, kc;
    slot_t         rd_slot;
    logic          fire;
    logic [CW-1:0] col_full;
    logic [CW-1:0] last_col;
    logic [RW-1:0] last_row;

    assign last_col = cfg_width - CW'(1);
    assign last_row = cfg_height - RW'(1);

    // A window is ready once its bottom-right pixel has been written.
    assign out_valid = frame_full || (wr_row > rd_row) ||
                       ((wr_row == rd_row) && (wr_col > rd_col));

    assign win_last   = (kr == 2'd2) && (kc == 2'd2);
    assign frame_last = win_last && (rd_row == last_row) && (rd_col == last_col);
    assign fire       = out_valid && out_ready;
    assign frame_done = fire && frame_last;

    // Address of the current element: the top window row sits one slot after the bottom row.
    always_comb begin
        sel_slot = slot_offset(slot_step(rd_slot), kr);
        col_full = rd_col - CW'(2) + {{(CW-2){1'b0}}, kc};
        sel_col  = col_full[AW-1:0];
    end

    // Step kernel column, kernel row, window column, window row in that order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_row  <= RW'(2);
            rd_col  <= CW'(2);
            kr      <= 2'd0;
            kc      <= 2'd0;
            rd_slot <= 2'd2;
        end else if (fire) begin
            if (kc == 2'd2) begin
                kc <= 2'd0;
                if (kr == 2'd2) begin
                    kr <= 2'd0;
                    if (rd_col == last_col) begin
                        rd_col <= CW'(2);
                        if (rd_row == last_row) begin
                            rd_row  <= RW'(2);
                            rd_slot <= 2'd2;
                        end else begin
                            rd_row  <= rd_row + RW'(1);
                            rd_slot <= slot_step(rd_slot);
                        end
                    end else begin
                        rd_col <= rd_col + CW'(1);
                    end
                end else begin
                    kr <= kr + 2'd1;
                end
            end else begin
                kc <= kc + 2'd1;
            end
        end
    end

    AST_WIN_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n) (fire && !win_last) |=> out_valid); // R2
endmodule

// File: rtl/tri_row_window.sv
// Module tri_row_window: raster pixel stream in, serialized 3x3 windows
// out (stride 1, no padding), using a three-row circular line buffer.
// Assumes 3 <= cfg_width <= MAX_W and 3 <= cfg_height <= MAX_H, both
// constant for the duration of a frame.
module tri_row_window #(
    parameter int PIX_W = 8,
    parameter int MAX_W = 32,
    parameter int MAX_H = 32,
    localparam int CW   = $clog2(MAX_W + 1),
    localparam int RW   = $clog2(MAX_H + 1),
    localparam int AW   = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cfg_width,
    input  logic [RW-1:0]    cfg_height,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data,
    output logic             out_win_last,
    output logic             out_frame_last,
    input  logic             out_ready
);
    logic [RW-1:0] wr_row, rd_row;
    logic [CW-1:0] wr_col, rd_col;
    tw_pkg::slot_t wr_slot, sel_slot;
    logic [AW-1:0] sel_col;
    logic          wr_en, frame_full, frame_done;

    pixel_loader #(.CW(CW), .RW(RW)) i_loader (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_ready(in_ready), .rd_row(rd_row), .rd_col(rd_col),
        .frame_done(frame_done), .wr_row(wr_row), .wr_col(wr_col), .wr_slot(wr_slot),
        .wr_en(wr_en), .frame_full(frame_full)
    );

    window_walker #(.CW(CW), .RW(RW), .AW(AW)) i_walker (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .wr_row(wr_row), .wr_col(wr_col), .frame_full(frame_full), .out_ready(out_ready),
        .out_valid(out_valid), .win_last(out_win_last), .frame_last(out_frame_last),
        .sel_slot(sel_slot), .sel_col(sel_col), .rd_row(rd_row), .rd_col(rd_col),
        .frame_done(frame_done)
    );

    row_store #(.PIX_W(PIX_W), .DEPTH(MAX_W), .AW(AW)) i_store (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_col(wr_col[AW-1:0]),
        .wr_data(in_data), .rd_slot(sel_slot), .rd_col(sel_col), .rd_data(out_data)
    );

    AST_READER_LAG: assert property (@(posedge clk) disable iff (!rst_n) (!frame_full && wr_row >= RW'(3)) |-> (rd_row + RW'(1) >= wr_row)); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_win_last) && $stable(out_frame_last))); // R7
    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> (in_ready && !out_valid)); // R8
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready && out_frame_last) |=> !out_valid); // R6
endmodule

// File: tb/test_tri_row_window.sv
`timescale 1ns/1ps
module test_tri_row_window;
    localparam int PIX_W = 8;
    localparam int MAX_W = 32;
    localparam int MAX_H = 32;
    localparam int CW = $clog2(MAX_W + 1);
    localparam int RW = $clog2(MAX_H + 1);
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n;
    logic [CW-1:0] cfg_width;
    logic [RW-1:0] cfg_height;
    logic in_valid, in_ready, out_valid, out_win_last, out_frame_last, out_ready;
    logic [PIX_W-1:0] in_data, out_data;

    always #2.5 clk = ~clk;

    tri_row_window #(.PIX_W(PIX_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) i_tri_row_window (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_win_last(out_win_last),
        .out_frame_last(out_frame_last), .out_ready(out_ready)
    );

    int n_checks = 0, n_fail = 0, cyc = 0;
    bit timed_out = 0;
    int W, H, nwin;
    int m_acc, m_cons, m_frame, m_total, win_seen;
    bit pend_in, pend_out, pend_wlast, prev_stall;
    logic [PIX_W-1:0] prev_data;

    function automatic logic [PIX_W-1:0] pix(int f, int i, int j);
        return PIX_W'((f * 73) ^ (i * 29) ^ (j * 7) ^ (i * j * 3) ^ 8'h5A);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One clock of the behavioural model: apply last cycle's handshakes, compare, drive.
    task automatic step(int frames, int in_pct, int out_pct);
        int w, k, r, c, i, j, need;
        bit e_ready, e_valid;
        logic [PIX_W-1:0] e_data;
        @(negedge clk);
        cyc++;
        if (pend_in) begin m_acc++; m_total++; end
        if (pend_out) begin
            m_cons++;
            if (pend_wlast) win_seen++;
            if (m_cons == 9 * nwin) begin
                check(win_seen == nwin, "R3", "windows per frame", win_seen, nwin);
                m_cons = 0; m_acc = 0; m_frame++; win_seen = 0;
            end
        end
        w = m_cons / 9; k = m_cons % 9;
        r = 2 + w / (W - 2); c = 2 + w % (W - 2);
        e_valid = (m_acc > r * W + c);
        if (m_acc == W * H) e_ready = 0;
        else begin
            i = m_acc / W; j = m_acc % W;
            if (i < 3) e_ready = 1;
            else begin
                need = (i - 3) * (W - 2) + (((j + 1) < (W - 2)) ? (j + 1) : (W - 2));
                e_ready = (m_cons / 9 >= need);
            end
        end
        check(in_ready == e_ready, (m_acc == W * H) ? "R8" : "R5", "in_ready", in_ready, e_ready);
        check(out_valid == e_valid, "R4", "out_valid", out_valid, e_valid);
        if (prev_stall)
            check(out_valid && out_data == prev_data, "R7", "held data", out_data, prev_data);
        if (out_valid && e_valid) begin
            e_data = pix(m_frame, r - 2 + k / 3, c - 2 + k % 3);
            check(out_data == e_data, "R2", "element data", out_data, e_data);
            check(out_win_last == (k == 8), "R6", "win_last", out_win_last, k == 8);
            check(out_frame_last == (k == 8 && w == nwin - 1), "R6", "frame_last",
                  out_frame_last, k == 8 && w == nwin - 1);
        end
        in_valid = (m_total < frames * W * H) && ($urandom_range(99) < in_pct);
        in_data = (m_acc < W * H) ? pix(m_frame, m_acc / W, m_acc % W) : pix(m_frame + 1, 0, 0);
        out_ready = ($urandom_range(99) < out_pct);
        pend_in = in_valid && in_ready;
        pend_out = out_valid && out_ready;
        pend_wlast = out_win_last;
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
    endtask

    task automatic run_cfg(int wd, int ht, int frames, int in_pct, int out_pct);
        @(negedge clk);
        W = wd; H = ht; nwin = (wd - 2) * (ht - 2);
        cfg_width = CW'(wd); cfg_height = RW'(ht);
        m_acc = 0; m_cons = 0; m_frame = 0; m_total = 0; win_seen = 0;
        pend_in = 0; pend_out = 0; prev_stall = 0;
        while (m_frame < frames && !timed_out) begin
            step(frames, in_pct, out_pct);
            if (cyc > WATCHDOG) begin
                timed_out = 1;
                check(0, "R9", "watchdog expired", cyc, WATCHDOG);
            end
        end
        check(m_frame == frames, "R9", "frames completed", m_frame, frames);
    endtask

    initial begin
        rst_n = 0; in_valid = 0; in_data = '0; out_ready = 0;
        cfg_width = CW'(9); cfg_height = RW'(9);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        run_cfg(9, 9, 2, 100, 100);   // R3: 7x7 windows, both streams at full rate
        run_cfg(9, 9, 2, 60, 40);     // R7: consumer stalls
        run_cfg(3, 3, 3, 100, 100);   // R9: single window frame
        run_cfg(5, 4, 2, 30, 100);    // R4: sparse input
        run_cfg(32, 5, 1, 100, 20);   // R5: widest rows, slow consumer
        run_cfg(4, 32, 1, 80, 80);    // R9: tallest frame
        run_cfg(7, 3, 2, 50, 50);     // R8: back-to-back frames, one window row
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule